// File: doc/BRIEF.md
# Program Counter and Return-Address Stack

This block produces the instruction fetch address for a small core with separate program and data memories. A 13-bit counter steps through the program one word per enabled cycle. It can also be redirected to a jump or call target, to the top of a circular eight-entry return-address stack, or to a fixed interrupt entry address. A synchronous reset puts the counter at address zero. Only the lowest 1K words of the 8K address space are backed by memory, so the fetch address leaves the block cut down to its 10 low bits.

Every change of flow costs two enabled cycles. In the first cycle the counter takes the new address and `flush` rises. The following enabled cycle is a bubble: the counter holds, so the instruction at the new address is fetched again before it runs. In the bubble, jump, call and return strobes are ignored. An interrupt accept is still taken. Pulling `step` low freezes the counter, the stack and `flush`.

The strobes refer to the instruction at the current address. A call therefore saves the current address plus one. An interrupt saves the current address itself, because that instruction has not yet run. No data stream crosses this block's boundary, so it has no valid/ready handshake. Every pin is a plain control or status signal, and the block never applies back-pressure.

Top module: `pc_sequencer`

## Requirements
- R1: A cycle with `rst` high leaves `fetch_addr` = 0, `stk_ptr` = 0 and `flush` = 0 after the edge, regardless of any other input.
- R2: With `step` high, `flush` low and no strobe, the counter increases by one at the edge.
- R3: With `step` high and `flush` low, `jump` loads `target` into the counter and raises `flush` for the next cycle.
- R4: A `call` taken in a non-bubble cycle stores the current address plus one on the stack, increments `stk_ptr`, loads `target` and raises `flush`.
- R5: A `ret` taken in a non-bubble cycle loads the most recently stored entry into the counter, decrements `stk_ptr` and raises `flush`.
- R6: `irq_ack` with `step` high stores the current address on the stack, increments `stk_ptr`, loads address 0x0004 and raises `flush`. This holds in any cycle, bubble cycles included. It takes precedence over `call`, `ret` and `jump` in the same cycle.
- R7: In an enabled cycle with `flush` high and no `irq_ack`, the counter and `stk_ptr` hold, `flush` falls, and `jump`, `call` and `ret` have no effect.
- R8: With `step` low, `fetch_addr`, `stk_ptr` and `flush` keep their values whatever the strobes carry.
- R9: `fetch_addr` is bits 9:0 of the 13-bit counter. A target of 0x1C05 shows as 0x005, and stepping from 0x3FF shows as 0x000.
- R10: `stk_ptr` counts modulo 8. A ninth store overwrites the oldest entry, and a removal at `stk_ptr` = 0 reads entry 7. There is no overflow or underflow flag.
- R11: When strobes coincide without `irq_ack`, `ret` wins over `call`, and `call` wins over `jump`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance enable; low stalls the block |
| jump | input | 1 | Load `target` into the counter |
| call | input | 1 | Save return address, load `target` |
| ret | input | 1 | Load counter from the stack top |
| irq_ack | input | 1 | Interrupt accepted: save address, go to 0x0004 |
| target | input | 13 | Jump or call destination |
| fetch_addr | output | 10 | Program memory fetch address |
| stk_ptr | output | 3 | Stack pointer, next free slot (debug) |
| flush | output | 1 | Marks the bubble cycle after a change of flow |

## Verification
All three outputs come from registers, so each result appears exactly one clock edge after the inputs that caused it. The bubble behaviour shows up one further enabled edge later, when `flush` falls while the address holds. The bench drives inputs on the falling edge and reads outputs on the next falling edge. Each check therefore sees the state left by exactly one rising edge. Stack tests that push nine times and then pop repeatedly count one call plus one bubble per store, and compare each popped address on the edge after its `ret`.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    OP_STALL  = 3'd0,
    OP_BUBBLE = 3'd1,
    OP_INC    = 3'd2,
    OP_JUMP   = 3'd3,
    OP_CALL   = 3'd4,
    OP_RET    = 3'd5,
    OP_IRQ    = 3'd6
  } flow_op_e;

  function automatic logic op_redirects(flow_op_e op);
    return (op == OP_JUMP) || (op == OP_CALL) || (op == OP_RET) || (op == OP_IRQ);
  endfunction
endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
(
  input  logic     step,
  input  logic     in_bubble,
  input  logic     jump,
  input  logic     call,
  input  logic     ret,
  input  logic     irq_ack,
  output flow_op_e op
);
  // Priority: stall, interrupt, bubble, return, call, jump, increment.
  always_comb begin
    if (!step)          op = OP_STALL;
    else if (irq_ack)   op = OP_IRQ;
    else if (in_bubble) op = OP_BUBBLE;
    else if (ret)       op = OP_RET;
    else if (call)      op = OP_CALL;
    else if (jump)      op = OP_JUMP;
    else                op = OP_INC;
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic [W-1:0]    push_val,
  output logic [W-1:0]    top_val,
  output logic [SP_W-1:0] sp
);
  logic [W-1:0]    ent [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] top_idx;

  // DEPTH is a power of two, so the pointer wraps by plain overflow.
  assign top_idx = sp_q - SP_W'(1);
  assign top_val = ent[top_idx];
  assign sp      = sp_q;

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (push) sp_q <= sp_q + SP_W'(1);
    else if (pop)  sp_q <= top_idx;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                                ent[i] <= '0;
      else if (push && (sp_q == SP_W'(i)))    ent[i] <= push_val;
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IMPL_W  = 10,
  parameter int DEPTH   = 8,
  parameter int RST_VEC = 0,
  parameter int IRQ_VEC = 4,
  localparam int SP_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              jump,
  input  logic              call,
  input  logic              ret,
  input  logic              irq_ack,
  input  logic [ADDR_W-1:0] target,
  output logic [IMPL_W-1:0] fetch_addr,
  output logic [SP_W-1:0]   stk_ptr,
  output logic              flush
);
  flow_op_e          op;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc, stk_top, push_val;
  logic              flush_q, flush_d;
  logic              push, pop;

  pcseq_decode u_dec (
    .step      (step),
    .in_bubble (flush_q),
    .jump      (jump),
    .call      (call),
    .ret       (ret),
    .irq_ack   (irq_ack),
    .op        (op)
  );

  assign pc_inc   = pc_q + ADDR_W'(1);
  assign push     = (op == OP_CALL) || (op == OP_IRQ);
  assign pop      = (op == OP_RET);
  assign push_val = (op == OP_IRQ) ? pc_q : pc_inc;

  pcseq_stack #(.W(ADDR_W), .DEPTH(DEPTH)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .push_val (push_val),
    .top_val  (stk_top),
    .sp       (stk_ptr)
  );

  always_comb begin
    unique case (op)
      OP_INC:           pc_d = pc_inc;
      OP_JUMP, OP_CALL: pc_d = target;
      OP_RET:           pc_d = stk_top;
      OP_IRQ:           pc_d = ADDR_W'(IRQ_VEC);
      default:          pc_d = pc_q;
    endcase
  end

  always_comb begin
    if (op == OP_STALL) flush_d = flush_q;
    else                flush_d = op_redirects(op);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= ADDR_W'(RST_VEC);
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      flush_q <= flush_d;
    end
  end

  assign fetch_addr = pc_q[IMPL_W-1:0];
  assign flush      = flush_q;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int ADDR_W  = 13,
  parameter int IMPL_W  = 10,
  parameter int SP_W    = 3,
  parameter int IRQ_VEC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic              jump,
  input logic              call,
  input logic              ret,
  input logic              irq_ack,
  input logic [ADDR_W-1:0] target,
  input logic [IMPL_W-1:0] fetch_addr,
  input logic [SP_W-1:0]   stk_ptr,
  input logic              flush
);
  logic plain;
  assign plain = step && !flush && !irq_ack;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0 && stk_ptr == '0 && !flush));

  assert_increment_R2: assert property (@(posedge clk) disable iff (rst)
    plain && !jump && !call && !ret |=> fetch_addr == $past(fetch_addr) + IMPL_W'(1));

  assert_jump_load_R3: assert property (@(posedge clk) disable iff (rst)
    plain && jump && !call && !ret |=> flush && fetch_addr == $past(target[IMPL_W-1:0]));

  assert_call_push_R4: assert property (@(posedge clk) disable iff (rst)
    plain && call && !ret |=> flush && stk_ptr == $past(stk_ptr) + SP_W'(1));

  assert_ret_pop_R5: assert property (@(posedge clk) disable iff (rst)
    plain && ret |=> flush && stk_ptr == $past(stk_ptr) - SP_W'(1));

  assert_irq_entry_R6: assert property (@(posedge clk) disable iff (rst)
    step && irq_ack |=> flush && fetch_addr == IMPL_W'(IRQ_VEC)
                        && stk_ptr == $past(stk_ptr) + SP_W'(1));

  assert_bubble_hold_R7: assert property (@(posedge clk) disable iff (rst)
    step && flush && !irq_ack |=> !flush && $stable(fetch_addr) && $stable(stk_ptr));

  assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(fetch_addr) && $stable(stk_ptr) && $stable(flush));
endmodule

bind pc_sequencer pc_sequencer_chk #(
  .ADDR_W (ADDR_W),
  .IMPL_W (IMPL_W),
  .SP_W   (SP_W),
  .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step       (step),
  .jump       (jump),
  .call       (call),
  .ret        (ret),
  .irq_ack    (irq_ack),
  .target     (target),
  .fetch_addr (fetch_addr),
  .stk_ptr    (stk_ptr),
  .flush      (flush)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // control field order: {step, jump, call, ret, irq_ack}
  localparam logic [4:0] C_STL = 5'b00000;
  localparam logic [4:0] C_INC = 5'b10000;
  localparam logic [4:0] C_JMP = 5'b11000;
  localparam logic [4:0] C_CAL = 5'b10100;
  localparam logic [4:0] C_RET = 5'b10010;
  localparam logic [4:0] C_IRQ = 5'b10001;

  typedef struct packed {
    logic [4:0]  ctl;
    logic [12:0] tgt;
    logic [9:0]  e_addr;
    logic [2:0]  e_sp;
    logic        e_fl;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{C_INC, 13'h0000, 10'h001, 3'd0, 1'b0},             // R2
    '{C_INC, 13'h0000, 10'h002, 3'd0, 1'b0},             // R2
    '{C_JMP, 13'h0100, 10'h100, 3'd0, 1'b1},             // R3
    '{C_JMP, 13'h0200, 10'h100, 3'd0, 1'b0},             // R7 jump ignored
    '{C_CAL, 13'h0050, 10'h050, 3'd1, 1'b1},             // R4 saves 0x101
    '{C_INC, 13'h0000, 10'h050, 3'd1, 1'b0},             // R7
    '{C_INC, 13'h0000, 10'h051, 3'd1, 1'b0},             // R2
    '{5'b01000, 13'h0300, 10'h051, 3'd1, 1'b0},          // R8 stall
    '{C_CAL, 13'h0060, 10'h060, 3'd2, 1'b1},             // R4 saves 0x052
    '{C_STL, 13'h0000, 10'h060, 3'd2, 1'b1},             // R8 flush held
    '{C_INC, 13'h0000, 10'h060, 3'd2, 1'b0},             // R7
    '{C_RET, 13'h0000, 10'h052, 3'd1, 1'b1},             // R5
    '{C_INC, 13'h0000, 10'h052, 3'd1, 1'b0},             // R7
    '{C_IRQ | C_CAL, 13'h0070, 10'h004, 3'd2, 1'b1},     // R6 beats call
    '{C_INC, 13'h0000, 10'h004, 3'd2, 1'b0},             // R7
    '{C_INC, 13'h0000, 10'h005, 3'd2, 1'b0},             // R2
    '{C_RET, 13'h0000, 10'h052, 3'd1, 1'b1},             // R6 saved own addr
    '{C_INC, 13'h0000, 10'h052, 3'd1, 1'b0},             // R7
    '{C_RET | C_CAL | C_JMP, 13'h0077, 10'h101, 3'd0, 1'b1}, // R11 ret wins
    '{C_INC, 13'h0000, 10'h101, 3'd0, 1'b0},             // R7
    '{C_CAL | C_JMP, 13'h00AA, 10'h0AA, 3'd1, 1'b1},     // R11 call wins
    '{C_INC, 13'h0000, 10'h0AA, 3'd1, 1'b0},             // R7
    '{C_JMP, 13'h1C05, 10'h005, 3'd1, 1'b1},             // R9 reduced
    '{C_INC, 13'h0000, 10'h005, 3'd1, 1'b0},             // R7
    '{C_RET, 13'h0000, 10'h102, 3'd0, 1'b1},             // R5
    '{C_INC, 13'h0000, 10'h102, 3'd0, 1'b0},             // R7
    '{C_JMP, 13'h03FF, 10'h3FF, 3'd0, 1'b1},             // R3
    '{C_INC, 13'h0000, 10'h3FF, 3'd0, 1'b0},             // R7
    '{C_INC, 13'h0000, 10'h000, 3'd0, 1'b0},             // R9 0x3FF -> 0x400
    '{C_JMP, 13'h0020, 10'h020, 3'd0, 1'b1},             // R3
    '{C_IRQ, 13'h0000, 10'h004, 3'd1, 1'b1},             // R6 in bubble
    '{C_INC, 13'h0000, 10'h004, 3'd1, 1'b0},             // R7
    '{C_RET, 13'h0000, 10'h020, 3'd0, 1'b1},             // R6 saved target
    '{C_INC, 13'h0000, 10'h020, 3'd0, 1'b0}              // R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0, jump = 1'b0, call = 1'b0, ret = 1'b0, irq_ack = 1'b0;
  logic [12:0] target = '0;
  logic [9:0]  fetch_addr;
  logic [2:0]  stk_ptr;
  logic        flush;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  pc_sequencer dut (
    .clk(clk), .rst(rst), .step(step), .jump(jump), .call(call), .ret(ret),
    .irq_ack(irq_ack), .target(target), .fetch_addr(fetch_addr),
    .stk_ptr(stk_ptr), .flush(flush)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [12:0] t);
    {step, jump, call, ret, irq_ack} = c;
    target = t;
    @(negedge clk);
  endtask

  task automatic chk_all(input string req, input int a, input int s, input int f);
    chk({req, " addr"}, int'(fetch_addr), a);
    chk({req, " sp"}, int'(stk_ptr), s);
    chk({req, " flush"}, int'(flush), f);
  endtask

  int vals [9];

  initial begin
    @(negedge clk);
    rst = 1'b1;
    drive(C_INC, 13'h0);
    rst = 1'b0;
    chk_all("R1 reset", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].ctl, VEC[i].tgt);
      chk_all($sformatf("vector %0d", i), int'(VEC[i].e_addr),
              int'(VEC[i].e_sp), int'(VEC[i].e_fl));
    end

    // R1: reset mid-run with strobes present
    rst = 1'b1;
    drive(C_CAL | C_IRQ, 13'h0155);
    rst = 1'b0;
    chk_all("R1 reset mid-run", 0, 0, 0);

    // R10: nine calls, each followed by its bubble
    for (int k = 0; k < 9; k++) begin
      vals[k] = (k == 0) ? 1 : (13'h100 + (k - 1) * 16 + 1);
      drive(C_CAL, 13'(13'h100 + k * 16));
      drive(C_INC, 13'h0);
    end
    chk("R10 sp after nine pushes", int'(stk_ptr), 1);
    for (int j = 0; j < 9; j++) begin
      int e;
      e = (j == 0 || j == 8) ? vals[8] : vals[8 - j];
      drive(C_RET, 13'h0);
      chk($sformatf("R10 pop %0d addr", j), int'(fetch_addr), e & 10'h3FF);
      chk($sformatf("R10 pop %0d sp", j), int'(stk_ptr), (1 - (j + 1)) & 7);
      drive(C_INC, 13'h0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule